// File: doc/BRIEF.md
# Sensor Bus Slave Command Handler

This block sits behind the bit-level receiver of a slave on a daisy-chained two-wire sensor bus. Each received command arrives as one already-deserialized word with a strobe and a flag telling whether it was a long (20-bit) or a short (12-bit) frame. The handler checks the frame's 4-bit CRC and compares the command address with the slave's own address register. It then executes the two commands it owns: writing the slave address into a one-time nonvolatile store, and driving the logic-out pin low. Every other command code is left to neighbouring decoders.

Replies are never sent in the slot of the command. The handler builds the reply frame when the command is accepted. It holds the frame until the next message strobe, and presents it during that next message. The reply is long or short to match the frame being exchanged at that moment. The nonvolatile store is modelled as a value register with a blank flag that survives power-up resets and is cleared only by an erase input. The address register is loaded from the store on every power-up, or is set dynamically while the store is blank or holds zero.

Top module: `scb_slave_cmd`

## Requirements
- R1: A frame whose CRC field (bits 3:0) differs from the CRC of the bits ahead of it is ignored: no change to logic-out, store or address, and an empty reply in the next slot. The CRC uses polynomial x^4+x+1 and seed 0000, fed MSB first. It covers bits 19:4 of a long frame and bits 11:4 of a short frame.
- R2: A command acts only when its address field (bits 11:8) equals the device address register.
- R3: The store-write command is accepted only as a long frame. Bits 19:16 must be 1111, bits 15:12 hold the value to store, and bits 7:4 must be 1001. The address field must equal bits 15:12. A short frame with those bits, or a mismatching value field, is ignored.
- R4: An accepted store-write on a blank store saves the value, clears blank and raises `nv_flag` on the next clock. On a written store it changes nothing. The stored value becomes the device address after each later power-up.
- R5: A reply staged by the command of slot n appears on the `rsp_*` outputs the clock after the strobe of slot n+1. It is held until the following strobe and is then replaced by the reply of slot n+1, or by an empty reply.
- R6: A command with address field 0 still takes effect but stages no reply.
- R7: A store-write reply carries a high byte of {address, 0000} and a low byte of {1111, stored value}. The stored value is the newly written one when the store was blank, and the old one otherwise.
- R8: The clear command (bits 7:4 = 1100, long or short) drives `logic_out` low the clock after its strobe. Its reply carries a high byte of {address, 0000} and a low byte of {nv, undervoltage, 0, switch closed, io[3:0]}, with the status sampled at the strobe.
- R9: A reply sent during a long slot is {high, low, CRC over 16 bits}. A reply sent during a short slot is {8'h00, low, CRC over 8 bits}. An empty reply is all zero with `rsp_valid` low.
- R10: `logic_out` is low after power-up and the clock after `bus_clear`. `lo_set` raises it, and any clear wins over a set in the same cycle.
- R11: On the first clock after power-up release, the address loads 0 if the store is blank, or the stored value otherwise. After that, `asg_valid` loads `asg_addr` only while the store is blank or holds 0.
- R12: Power-up reset clears the staged and presented reply and `logic_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| erase_n | input | 1 | Active-low asynchronous erase of the nonvolatile model (blank state) |
| por_n | input | 1 | Active-low asynchronous power-up reset |
| cmd_valid | input | 1 | One-cycle strobe: a command word was received (message boundary) |
| cmd_long | input | 1 | 1 = long 20-bit frame, 0 = short 12-bit frame in bits 11:0 |
| cmd_word | input | 20 | Received command frame |
| asg_valid | input | 1 | Dynamic address assignment strobe from the initialization decoder |
| asg_addr | input | 4 | Dynamically assigned address |
| lo_set | input | 1 | Set request for logic-out from the neighbouring decoder |
| bus_clear | input | 1 | Bus-wide clear: forces logic-out low |
| sw_closed | input | 1 | Bus switch position, 1 = closed |
| undervolt | input | 1 | Undervoltage flag |
| io_level | input | 4 | Logic I/O pin levels |
| rsp_valid | output | 1 | A reply is presented in the current slot |
| rsp_long | output | 1 | Current slot is long |
| rsp_word | output | 20 | Reply frame including slave CRC |
| logic_out | output | 1 | Logic-out pin level |
| dev_addr | output | 4 | Device address register |
| nv_flag | output | 1 | Nonvolatile store has been written |

## Verification
Logic-out, the store flags and the address register change on the first clock edge after the strobe or request that drives them. The reply of a command shows up one edge after the next message strobe, not after its own. The bench drives inputs at falling edges and steps a behavioural model once per rising edge. It then compares every output at the following falling edge, so each result is checked in exactly the cycle it falls due. The model keeps the staged reply as separate state, so a reply that arrives a slot early or late shows as a mismatch on that cycle.

// File: rtl/scb_pkg.sv
package scb_pkg;
   localparam int unsigned NIB_W   = 4;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned FRAME_W = 2 * BYTE_W + NIB_W;

   typedef struct packed {
      logic              valid;
      logic [BYTE_W-1:0] hi;
      logic [BYTE_W-1:0] lo;
   } scb_reply_t;
endpackage

// File: rtl/scb_crc4.sv
module scb_crc4 #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CRC_W  = 4,
   parameter int unsigned POLY   = 3
) (
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc
);
   localparam logic [CRC_W-1:0] POLY_V = CRC_W'(POLY);

   if (DATA_W < 1 || CRC_W < 2) begin : g_bad_cfg
      $error("scb_crc4: DATA_W must be >= 1 and CRC_W >= 2");
   end

   always_comb begin
      logic [CRC_W-1:0] acc;
      logic             fb;
      acc = '0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb  = acc[CRC_W-1] ^ data[i];
         acc = {acc[CRC_W-2:0], 1'b0};
         if (fb) acc = acc ^ POLY_V;
      end
      crc = acc;
   end
endmodule

// File: rtl/scb_cmd_decode.sv
module scb_cmd_decode #(
   parameter int unsigned     ADDR_W     = 4,
   parameter int unsigned     CRC_W      = 4,
   parameter int unsigned     DATA_W     = 8,
   parameter logic [3:0]      NVM_OP     = 4'b1001,
   parameter logic [3:0]      CLR_OP     = 4'b1100,
   parameter bit              LONG_CLEAR = 1'b1,
   localparam int unsigned    FRAME_W    = DATA_W + 2 * ADDR_W + CRC_W,
   localparam int unsigned    LONG_B     = FRAME_W - CRC_W,
   localparam int unsigned    SHORT_B    = 2 * ADDR_W
) (
   input  logic               cmd_long,
   input  logic [FRAME_W-1:0] cmd_word,
   input  logic [ADDR_W-1:0]  dev_addr,
   output logic               hit_nvm,
   output logic               hit_clr,
   output logic [ADDR_W-1:0]  cmd_addr,
   output logic [ADDR_W-1:0]  prog_val
);
   logic [CRC_W-1:0]  crc_l;
   logic [CRC_W-1:0]  crc_s;
   logic              crc_ok;
   logic              addr_ok;
   logic              len_ok_clr;
   logic [ADDR_W-1:0] op;
   logic [ADDR_W-1:0] marker;

   scb_crc4 #(.DATA_W(LONG_B), .CRC_W(CRC_W)) u_crc_long (
      .data (cmd_word[FRAME_W-1:CRC_W]),
      .crc  (crc_l)
   );

   scb_crc4 #(.DATA_W(SHORT_B), .CRC_W(CRC_W)) u_crc_short (
      .data (cmd_word[SHORT_B+CRC_W-1:CRC_W]),
      .crc  (crc_s)
   );

   if (LONG_CLEAR) begin : g_clr_any_len
      assign len_ok_clr = 1'b1;
   end else begin : g_clr_short_only
      assign len_ok_clr = ~cmd_long;
   end

   always_comb begin
      cmd_addr = cmd_word[CRC_W+2*ADDR_W-1 -: ADDR_W];
      op       = cmd_word[CRC_W+ADDR_W-1 -: ADDR_W];
      prog_val = cmd_word[CRC_W+3*ADDR_W-1 -: ADDR_W];
      marker   = cmd_word[FRAME_W-1 -: ADDR_W];
      crc_ok   = cmd_long ? (crc_l == cmd_word[CRC_W-1:0])
                          : (crc_s == cmd_word[CRC_W-1:0]);
      addr_ok  = (cmd_addr == dev_addr);
      hit_nvm  = crc_ok && addr_ok && cmd_long && (marker == '1)
              && (prog_val == cmd_addr) && (op == NVM_OP[ADDR_W-1:0]);
      hit_clr  = crc_ok && addr_ok && len_ok_clr && (op == CLR_OP[ADDR_W-1:0]);
   end
endmodule

// File: rtl/scb_nvm_store.sv
module scb_nvm_store #(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              erase_n,
   input  logic              por_n,
   input  logic              prog_en,
   input  logic [ADDR_W-1:0] prog_val,
   input  logic              asg_valid,
   input  logic [ADDR_W-1:0] asg_addr,
   output logic              blank,
   output logic [ADDR_W-1:0] stored,
   output logic [ADDR_W-1:0] dev_addr
);
   logic boot_pend;
   logic dyn_ok;

   assign dyn_ok = blank || (stored == '0);

   always_ff @(posedge clk or negedge erase_n) begin
      if (!erase_n) begin
         blank  <= 1'b1;
         stored <= '0;
      end else if (prog_en && blank) begin
         blank  <= 1'b0;
         stored <= prog_val;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         boot_pend <= 1'b1;
         dev_addr  <= '0;
      end else if (boot_pend) begin
         boot_pend <= 1'b0;
         dev_addr  <= blank ? '0 : stored;
      end else if (asg_valid && dyn_ok) begin
         dev_addr  <= asg_addr;
      end
   end

   p_written_frozen_r4: assert property (@(posedge clk) disable iff (!erase_n)
      !blank |=> ($stable(stored) && !blank));

   p_asg_locked_r11: assert property (@(posedge clk) disable iff (!erase_n || !por_n)
      (!boot_pend && !dyn_ok) |=> $stable(dev_addr));
endmodule

// File: rtl/scb_rsp_stage.sv
module scb_rsp_stage
   import scb_pkg::*;
#(
   parameter int unsigned  CRC_W   = 4,
   localparam int unsigned LONG_B  = 2 * BYTE_W,
   localparam int unsigned OUT_W   = LONG_B + CRC_W
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             cmd_valid,
   input  logic             cmd_long,
   input  scb_reply_t       new_reply,
   output logic             stg_valid,
   output logic             rsp_valid,
   output logic             rsp_long,
   output logic [OUT_W-1:0] rsp_word
);
   scb_reply_t       stg;
   logic [CRC_W-1:0] crc_l;
   logic [CRC_W-1:0] crc_s;
   logic [OUT_W-1:0] frame;

   scb_crc4 #(.DATA_W(LONG_B), .CRC_W(CRC_W)) u_crc_long (
      .data ({stg.hi, stg.lo}),
      .crc  (crc_l)
   );

   scb_crc4 #(.DATA_W(BYTE_W), .CRC_W(CRC_W)) u_crc_short (
      .data (stg.lo),
      .crc  (crc_s)
   );

   always_comb begin
      if (!stg.valid)    frame = '0;
      else if (cmd_long) frame = {stg.hi, stg.lo, crc_l};
      else               frame = {{BYTE_W{1'b0}}, stg.lo, crc_s};
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         stg       <= '0;
         rsp_valid <= 1'b0;
         rsp_long  <= 1'b0;
         rsp_word  <= '0;
      end else if (cmd_valid) begin
         stg       <= new_reply;
         rsp_valid <= stg.valid;
         rsp_long  <= cmd_long;
         rsp_word  <= frame;
      end
   end

   assign stg_valid = stg.valid;

   p_reply_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
      !cmd_valid |=> ($stable(rsp_word) && $stable(rsp_valid) && $stable(rsp_long)));
endmodule

// File: rtl/scb_slave_cmd.sv
module scb_slave_cmd
   import scb_pkg::*;
#(
   parameter int unsigned  ADDR_W     = 4,
   parameter int unsigned  CRC_W      = 4,
   parameter int unsigned  DATA_W     = 8,
   parameter int unsigned  IO_W       = 4,
   parameter logic [3:0]   NVM_OP     = 4'b1001,
   parameter logic [3:0]   CLR_OP     = 4'b1100,
   parameter bit           LONG_CLEAR = 1'b1,
   localparam int unsigned FRM_W      = DATA_W + 2 * ADDR_W + CRC_W,
   localparam int unsigned PAD_W      = DATA_W - ADDR_W
) (
   input  logic              clk,
   input  logic              erase_n,
   input  logic              por_n,
   input  logic              cmd_valid,
   input  logic              cmd_long,
   input  logic [FRM_W-1:0]  cmd_word,
   input  logic              asg_valid,
   input  logic [ADDR_W-1:0] asg_addr,
   input  logic              lo_set,
   input  logic              bus_clear,
   input  logic              sw_closed,
   input  logic              undervolt,
   input  logic [IO_W-1:0]   io_level,
   output logic              rsp_valid,
   output logic              rsp_long,
   output logic [FRM_W-1:0]  rsp_word,
   output logic              logic_out,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              nv_flag
);
   if (ADDR_W != NIB_W || CRC_W != NIB_W || DATA_W != BYTE_W || IO_W != NIB_W) begin : g_bad_cfg
      $error("scb_slave_cmd: frame layout fixes ADDR_W, CRC_W, IO_W at 4 and DATA_W at 8");
   end

   logic              hit_nvm;
   logic              hit_clr;
   logic [ADDR_W-1:0] cmd_addr;
   logic [ADDR_W-1:0] prog_val;
   logic              blank;
   logic [ADDR_W-1:0] stored;
   logic              acc_nvm;
   logic              acc_clr;
   logic              stg_valid;
   scb_reply_t        new_reply;

   scb_cmd_decode #(
      .ADDR_W     (ADDR_W),
      .CRC_W      (CRC_W),
      .DATA_W     (DATA_W),
      .NVM_OP     (NVM_OP),
      .CLR_OP     (CLR_OP),
      .LONG_CLEAR (LONG_CLEAR)
   ) u_decode (
      .cmd_long (cmd_long),
      .cmd_word (cmd_word),
      .dev_addr (dev_addr),
      .hit_nvm  (hit_nvm),
      .hit_clr  (hit_clr),
      .cmd_addr (cmd_addr),
      .prog_val (prog_val)
   );

   assign acc_nvm = cmd_valid && hit_nvm;
   assign acc_clr = cmd_valid && hit_clr;

   scb_nvm_store #(.ADDR_W(ADDR_W)) u_nvm (
      .clk       (clk),
      .erase_n   (erase_n),
      .por_n     (por_n),
      .prog_en   (acc_nvm),
      .prog_val  (prog_val),
      .asg_valid (asg_valid),
      .asg_addr  (asg_addr),
      .blank     (blank),
      .stored    (stored),
      .dev_addr  (dev_addr)
   );

   assign nv_flag = ~blank;

   always_comb begin
      new_reply       = '0;
      new_reply.hi    = {cmd_addr, {PAD_W{1'b0}}};
      if (acc_nvm) begin
         new_reply.valid = (cmd_addr != '0);
         new_reply.lo    = {{PAD_W{1'b1}}, (blank ? prog_val : stored)};
      end else if (acc_clr) begin
         new_reply.valid = (cmd_addr != '0);
         new_reply.lo    = {~blank, undervolt, 1'b0, sw_closed, io_level};
      end
   end

   scb_rsp_stage #(.CRC_W(CRC_W)) u_stage (
      .clk       (clk),
      .por_n     (por_n),
      .cmd_valid (cmd_valid),
      .cmd_long  (cmd_long),
      .new_reply (new_reply),
      .stg_valid (stg_valid),
      .rsp_valid (rsp_valid),
      .rsp_long  (rsp_long),
      .rsp_word  (rsp_word)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                    logic_out <= 1'b0;
      else if (bus_clear || acc_clr) logic_out <= 1'b0;
      else if (lo_set)               logic_out <= 1'b1;
   end

   p_clr_low_r8: assert property (@(posedge clk) disable iff (!por_n)
      (cmd_valid && hit_clr) |=> !logic_out);

   p_bus_clear_r10: assert property (@(posedge clk) disable iff (!por_n)
      bus_clear |=> !logic_out);

   p_zero_silent_r6: assert property (@(posedge clk) disable iff (!por_n)
      (cmd_valid && cmd_word[CRC_W+2*ADDR_W-1 -: ADDR_W] == '0) |=> !stg_valid);
endmodule

// File: tb/scb_slave_cmd_bench.sv
module scb_slave_cmd_bench;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        erase_n = 1'b0, por_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_long = 1'b0;
   logic [19:0] cmd_word = '0;
   logic        asg_valid = 1'b0;
   logic [3:0]  asg_addr = '0;
   logic        lo_set = 1'b0, bus_clear = 1'b0;
   logic        sw_closed = 1'b0, undervolt = 1'b0;
   logic [3:0]  io_level = '0;
   logic        rsp_valid, rsp_long, logic_out, nv_flag;
   logic [19:0] rsp_word;
   logic [3:0]  dev_addr;

   int compared = 0, mismatched = 0;
   bit done = 0;

   // reference model state
   bit       m_blank, m_boot, m_lo, m_stg_v, m_rv, m_rl;
   int       m_stored, m_dev, m_stg_hi, m_stg_lo;
   int       m_rw;

   always #(PERIOD/2) clk = ~clk;

   scb_slave_cmd u_scb_slave_cmd (
      .clk(clk), .erase_n(erase_n), .por_n(por_n),
      .cmd_valid(cmd_valid), .cmd_long(cmd_long), .cmd_word(cmd_word),
      .asg_valid(asg_valid), .asg_addr(asg_addr),
      .lo_set(lo_set), .bus_clear(bus_clear),
      .sw_closed(sw_closed), .undervolt(undervolt), .io_level(io_level),
      .rsp_valid(rsp_valid), .rsp_long(rsp_long), .rsp_word(rsp_word),
      .logic_out(logic_out), .dev_addr(dev_addr), .nv_flag(nv_flag)
   );

   // CRC by long division of the message augmented with four zero bits
   function automatic int crc_ref(input int v, input int n);
      int r = 0;
      for (int i = n - 1; i >= 0; i--) begin
         r = (r << 1) | ((v >> i) & 1);
         if ((r & 16) != 0) r = r ^ 19;
      end
      for (int k = 0; k < 4; k++) begin
         r = r << 1;
         if ((r & 16) != 0) r = r ^ 19;
      end
      return r;
   endfunction

   function automatic logic [19:0] mk_long(input int d, input int a, input int op);
      int v = (d << 8) | (a << 4) | op;
      return 20'((v << 4) | crc_ref(v, 16));
   endfunction

   function automatic logic [19:0] mk_short(input int a, input int op);
      int v = (a << 4) | op;
      return 20'((v << 4) | crc_ref(v, 8));
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      chk(tag, "rsp_valid", int'(rsp_valid), int'(m_rv));
      chk(tag, "rsp_long",  int'(rsp_long),  int'(m_rl));
      chk(tag, "rsp_word",  int'(rsp_word),  m_rw);
      chk(tag, "logic_out", int'(logic_out), int'(m_lo));
      chk(tag, "dev_addr",  int'(dev_addr),  m_dev);
      chk(tag, "nv_flag",   int'(nv_flag),   int'(!m_blank));
   endtask

   // one rising edge of the reference behaviour, using pre-edge values
   task automatic model_tick();
      int w = int'(cmd_word);
      int a = (w >> 8) & 15, op = (w >> 4) & 15, pa = (w >> 12) & 15, mk = (w >> 16) & 15;
      bit ok, hn, hc, nv_v;
      int n_hi, n_lo, n_dev, n_stored;
      bit n_blank;
      ok = cmd_long ? (crc_ref(w >> 4, 16) == (w & 15)) : (crc_ref((w >> 4) & 255, 8) == (w & 15));
      hn = cmd_valid && ok && a == m_dev && cmd_long && mk == 15 && pa == a && op == 9;
      hc = cmd_valid && ok && a == m_dev && op == 12;
      nv_v = 0; n_hi = a << 4; n_lo = 0;
      if (hn) begin nv_v = (a != 0); n_lo = 240 | (m_blank ? pa : m_stored); end
      else if (hc) begin
         nv_v = (a != 0);
         n_lo = (int'(!m_blank) << 7) | (int'(undervolt) << 6) | (int'(sw_closed) << 4) | int'(io_level);
      end
      if (cmd_valid) begin
         m_rv = m_stg_v;
         m_rl = cmd_long;
         if (!m_stg_v) m_rw = 0;
         else if (cmd_long) m_rw = (((m_stg_hi << 8) | m_stg_lo) << 4) | crc_ref((m_stg_hi << 8) | m_stg_lo, 16);
         else m_rw = (m_stg_lo << 4) | crc_ref(m_stg_lo, 8);
         m_stg_v = nv_v; m_stg_hi = n_hi; m_stg_lo = n_lo;
      end
      if (bus_clear || hc) m_lo = 0;
      else if (lo_set) m_lo = 1;
      n_blank = m_blank; n_stored = m_stored; n_dev = m_dev;
      if (hn && m_blank) begin n_blank = 0; n_stored = pa; end
      if (m_boot) begin n_dev = m_blank ? 0 : m_stored; m_boot = 0; end
      else if (asg_valid && (m_blank || m_stored == 0)) n_dev = int'(asg_addr);
      m_blank = n_blank; m_stored = n_stored; m_dev = n_dev;
   endtask

   task automatic step(input string tag);
      model_tick();
      @(posedge clk);
      @(negedge clk);
      compare_all(tag);
      cmd_valid = 0; asg_valid = 0; lo_set = 0; bus_clear = 0;
   endtask

   task automatic send(input string tag, input bit lng, input logic [19:0] w);
      cmd_valid = 1; cmd_long = lng; cmd_word = w;
      step(tag);
   endtask

   task automatic power_up(input bit erase, input string tag);
      por_n = 0;
      if (erase) begin erase_n = 0; m_blank = 1; m_stored = 0; end
      m_boot = 1; m_lo = 0; m_dev = 0; m_stg_v = 0; m_stg_hi = 0; m_stg_lo = 0;
      m_rv = 0; m_rl = 0; m_rw = 0;
      @(negedge clk); @(negedge clk);
      compare_all(tag);
      erase_n = 1; por_n = 1;
      step(tag);                       // boot load cycle
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         mismatched++; compared++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      power_up(1, "R12");                               // reset state, boot with blank store
      asg_valid = 1; asg_addr = 5; step("R11");         // dynamic address taken while blank
      lo_set = 1; step("R10");                          // logic-out raised
      send("R1", 0, mk_short(5, 12) ^ 20'h1);           // bad CRC clear: nothing happens
      send("R2", 0, mk_short(6, 12));                   // other slave's clear ignored
      sw_closed = 1; undervolt = 0; io_level = 4'hA;
      send("R8", 0, mk_short(5, 12));                   // clear: logic-out low, reply staged
      sw_closed = 0; io_level = 4'h3; undervolt = 1;
      send("R5", 1, mk_long(0, 6, 0));                  // staged clear reply shown in long slot (R9)
      send("R5", 0, mk_short(6, 0));                    // reply consumed, slot now empty
      lo_set = 1; step("R10");
      send("R3", 0, mk_short(5, 9));                    // short store-write ignored
      send("R3", 1, mk_long(8'hF3, 5, 9));              // value field differs from address
      send("R3", 1, mk_long(8'h75, 5, 9));              // marker nibble wrong
      send("R4", 1, mk_long(8'hF5, 5, 9));              // store written
      send("R7", 1, mk_long(0, 0, 0));                  // long store reply
      asg_valid = 1; asg_addr = 9; step("R11");         // locked: assignment ignored
      send("R4", 1, mk_long(8'hF5, 5, 9));              // written store: no change, reply stored value
      send("R9", 0, mk_short(0, 0));                    // short form of that reply
      send("R8", 1, mk_long(8'h00, 5, 12));             // long clear accepted
      power_up(0, "R12");                               // reply and logic-out cleared
      step("R4");                                       // address restored from store
      lo_set = 1; step("R10");
      lo_set = 1; bus_clear = 1; step("R10");           // clear beats set
      power_up(1, "R11");
      lo_set = 1; step("R10");
      send("R6", 0, mk_short(0, 12));                   // acted on, no reply
      send("R6", 1, mk_long(0, 7, 0));
      send("R6", 1, mk_long(8'hF0, 0, 9));              // stores 0 silently
      send("R6", 1, mk_long(0, 7, 0));
      power_up(0, "R11");
      asg_valid = 1; asg_addr = 4; step("R11");         // stored 0 keeps dynamic addressing
      send("R2", 0, mk_short(4, 12));
      send("R5", 0, mk_short(1, 0));
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule